// File: doc/BRIEF.md
# Serial Flash Programming Command Interface

This block is the serial front end used to program an on-chip code flash while the rest of the chip is held in reset. A host shifts fixed three-byte instructions in over a clock/data-in/data-out link. The block assembles each instruction, decodes it, and applies it to a behavioural flash array. The instructions are: enabling the interface, erasing the whole array, reading or writing one byte, and programming the lock bits. Write and erase take a timed busy period. Flash semantics hold: a write can only clear bits, so a byte is restored to FFh only by a full erase.

The link is sampled by the system clock. SCK and MOSI pass through a two-stage synchronizer. MOSI is captured on each rising SCK edge, and MISO is updated on each falling edge. Read data is returned on MISO during the third byte of a read instruction. A write still in progress can be detected by polling the same address. The three lock bits are exported to the neighbouring protection logic.

The array size is a parameter. The full product instance uses 12288 bytes. The default keeps the model small for elaboration. The 14-bit address layout does not depend on the array size.

Top module: `sprog_if`

## Requirements
- R1: Each instruction is 24 bits, shifted MSB first: byte 1, then byte 2, then byte 3. MOSI is captured on rising SCK edges. An instruction acts only once its 24th bit has arrived, and an incomplete frame has no effect.
- R2: While `prog_req` is low, the bit counter and MISO register are held cleared, no frame completes, and the enabled state is dropped. Any later instruction needs a new enable.
- R3: Enable is byte 1 = ACh and byte 2 = 53h, with byte 3 ignored. Until it has been received, erase, write and lock instructions are ignored, and a read returns 00h.
- R4: Chip erase is byte 1 = ACh with byte 2 bits [2:0] = 100, all other bits ignored. It sets every byte to FFh and clears all lock bits, and `busy` is held for ERASE_CYCLES clocks.
- R5: A read has byte 1 bits [1:0] = 01, and the address is {byte1[7:2], byte2}. The addressed byte is shifted out on MISO, MSB first, during the third byte, and MISO changes on falling SCK edges.
- R6: A write has byte 1 bits [1:0] = 10, the same address layout, and byte 3 as data. After WRITE_CYCLES clocks of `busy`, the stored byte becomes old AND data.
- R7: While a write is busy, a read of the address being written returns {~data[7], 7'b0}. Reads of other addresses return their stored value. After the busy period, the same read returns the true byte.
- R8: `busy` rises on the clock after the frame completes. It stays high for exactly WRITE_CYCLES clocks for a write and ERASE_CYCLES clocks for an erase.
- R9: An erase, write or lock instruction that completes while `busy` is high is ignored. Reads are still served.
- R10: Addresses at or above ARRAY_BYTES are out of range. A write to one is ignored and does not raise `busy`, and a read of one returns FFh.
- R11: Lock write is byte 1 = ACh with byte 2 bits [2:0] = 111. Byte 2 bits 5, 4 and 3 carry lock bits 1, 2 and 3, and a 0 programs the bit. `lock_bits[0]` is lock bit 1, `lock_bits[1]` is lock bit 2, and `lock_bits[2]` is lock bit 3, with 1 meaning programmed. A programmed bit stays set until a chip erase.
- R12: After reset, `busy`, `lock_bits` and `miso` are 0 and the interface is not enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| prog_req | input | 1 | Programming mode request (chip held in reset) |
| sck | input | 1 | Serial clock from host |
| mosi | input | 1 | Serial data from host |
| miso | output | 1 | Serial data to host |
| busy | output | 1 | Write or erase in progress |
| lock_bits | output | 3 | Programmed lock bits, bit 0 = lock bit 1 |

## Verification
A misaligned bit counter or wrong decode corrupts the next read within one 24-bit frame. It shows up as a wrong byte on MISO, or as `busy` rising or failing to rise right after the 24th bit. A stale busy counter or a lost pending address shows as a wrong length of `busy`, or as a poll value that outlives the write. A write that overwrites instead of ANDing shows on the next read of that address. Lock-bit state is visible directly on `lock_bits`, one clock after the lock frame completes.

// File: rtl/sprog_pkg.sv
package sprog_pkg;
  typedef enum logic [2:0] {
    OP_NONE,
    OP_ENABLE,
    OP_ERASE,
    OP_READ,
    OP_WRITE,
    OP_LOCK
  } op_e;

  typedef struct packed {
    op_e         op;
    logic [13:0] addr;
    logic [7:0]  data;
    logic [2:0]  lock_set;   // 1 = program this lock bit
  } cmd_t;

  localparam logic [7:0] PREFIX_B1 = 8'hAC;
  localparam logic [7:0] ENABLE_B2 = 8'h53;
endpackage

// File: rtl/sp_link.sv
module sp_link #(
  parameter int FRAME_BITS = 24
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  prog_req,
  input  logic                  sck,
  input  logic                  mosi,
  input  logic [7:0]            load_byte,
  output logic                  frm_valid,
  output logic [FRAME_BITS-1:0] frm_word,
  output logic [15:0]           head,
  output logic                  load_now,
  output logic                  miso
);
  localparam int BW = $clog2(FRAME_BITS);
  localparam logic [BW-1:0] LAST_BIT  = BW'(FRAME_BITS - 1);
  localparam logic [BW-1:0] HEAD_BITS = BW'(FRAME_BITS - 8);

  logic [2:0]            sck_q;
  logic [1:0]            mosi_q;
  logic [BW-1:0]         cnt_q, cnt_n;
  logic [FRAME_BITS-1:0] sh_q, sh_n;
  logic [7:0]            dout_q, dout_n;
  logic                  rise, fall;

  assign rise = sck_q[1] & ~sck_q[2];
  assign fall = ~sck_q[1] & sck_q[2];

  always_comb begin
    cnt_n     = cnt_q;
    sh_n      = sh_q;
    dout_n    = dout_q;
    frm_valid = 1'b0;
    load_now  = 1'b0;
    if (!prog_req) begin
      cnt_n  = '0;
      dout_n = '0;
    end else if (rise) begin
      sh_n      = {sh_q[FRAME_BITS-2:0], mosi_q[1]};
      frm_valid = (cnt_q == LAST_BIT);
      cnt_n     = (cnt_q == LAST_BIT) ? '0 : cnt_q + 1'b1;
    end else if (fall) begin
      load_now = (cnt_q == HEAD_BITS);
      dout_n   = load_now ? load_byte : {dout_q[6:0], 1'b0};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q  <= '0;
      mosi_q <= '0;
      cnt_q  <= '0;
      sh_q   <= '0;
      dout_q <= '0;
    end else begin
      sck_q  <= {sck_q[1:0], sck};
      mosi_q <= {mosi_q[0], mosi};
      cnt_q  <= cnt_n;
      sh_q   <= sh_n;
      dout_q <= dout_n;
    end
  end

  assign frm_word = sh_n;
  assign head     = sh_q[15:0];
  assign miso     = dout_q[7];
endmodule

// File: rtl/sp_decode.sv
module sp_decode
  import sprog_pkg::*;
(
  input  logic [23:0] word,
  output cmd_t        cmd
);
  logic [7:0] b1, b2;

  assign b1 = word[23:16];
  assign b2 = word[15:8];

  always_comb begin
    cmd.op       = OP_NONE;
    cmd.addr     = {b1[7:2], b2};
    cmd.data     = word[7:0];
    cmd.lock_set = ~{b2[3], b2[4], b2[5]};
    if (b1 == PREFIX_B1) begin
      if (b2 == ENABLE_B2)          cmd.op = OP_ENABLE;
      else if (b2[2:0] == 3'b100)   cmd.op = OP_ERASE;
      else if (b2[2:0] == 3'b111)   cmd.op = OP_LOCK;
    end else begin
      case (b1[1:0])
        2'b01:   cmd.op = OP_READ;
        2'b10:   cmd.op = OP_WRITE;
        default: cmd.op = OP_NONE;
      endcase
    end
  end
endmodule

// File: rtl/sp_store.sv
module sp_store #(
  parameter int DEPTH  = 2048,
  parameter int WR_CYC = 100000,
  parameter int ER_CYC = 1000000
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       start_wr,
  input  logic                       start_er,
  input  logic [$clog2(DEPTH)-1:0]   wr_addr,
  input  logic [7:0]                 wr_data,
  input  logic [13:0]                rd_addr,
  output logic                       busy,
  output logic [7:0]                 rd_data
);
  localparam int AW   = $clog2(DEPTH);
  localparam int LONG = (ER_CYC > WR_CYC) ? ER_CYC : WR_CYC;
  localparam int CW   = $clog2(LONG + 1);
  localparam logic [CW-1:0] WR_LAST   = CW'(WR_CYC - 1);
  localparam logic [CW-1:0] ER_LAST   = CW'(ER_CYC - 1);
  localparam logic [CW-1:0] SWEEP_END = CW'(DEPTH);
  localparam logic [14:0]   LIMIT     = 15'(DEPTH);

  logic [7:0]    mem [DEPTH];
  logic          busy_q, busy_n, erase_q, erase_n;
  logic [CW-1:0] cnt_q, cnt_n;
  logic [AW-1:0] paddr_q, paddr_n;
  logic [7:0]    pdata_q, pdata_n;
  logic          done, in_rng, poll;

  assign done = busy_q && (cnt_q == (erase_q ? ER_LAST : WR_LAST));

  always_comb begin
    busy_n  = busy_q;
    erase_n = erase_q;
    cnt_n   = cnt_q;
    paddr_n = paddr_q;
    pdata_n = pdata_q;
    if (busy_q) begin
      cnt_n = cnt_q + 1'b1;
      if (done) busy_n = 1'b0;
    end else if (start_er || start_wr) begin
      busy_n  = 1'b1;
      erase_n = start_er;
      cnt_n   = '0;
      paddr_n = wr_addr;
      pdata_n = wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      erase_q <= 1'b0;
      cnt_q   <= '0;
      paddr_q <= '0;
      pdata_q <= '0;
    end else begin
      busy_q  <= busy_n;
      erase_q <= erase_n;
      cnt_q   <= cnt_n;
      paddr_q <= paddr_n;
      pdata_q <= pdata_n;
    end
  end

  // Array cells carry no reset; erase sweeps one cell per busy cycle.
  always_ff @(posedge clk) begin
    if (busy_q && erase_q && (cnt_q < SWEEP_END))
      mem[cnt_q[AW-1:0]] <= 8'hFF;
    else if (done && !erase_q)
      mem[paddr_q] <= mem[paddr_q] & pdata_q;
  end

  assign in_rng = ({1'b0, rd_addr} < LIMIT);
  assign poll   = busy_q && !erase_q && (rd_addr[AW-1:0] == paddr_q);

  always_comb begin
    if (!in_rng)   rd_data = 8'hFF;
    else if (poll) rd_data = {~pdata_q[7], 7'b0};
    else           rd_data = mem[rd_addr[AW-1:0]];
  end

  assign busy = busy_q;
endmodule

// File: rtl/sprog_if.sv
module sprog_if
  import sprog_pkg::*;
#(
  parameter int ARRAY_BYTES  = 2048,
  parameter int WRITE_CYCLES = 100000,
  parameter int ERASE_CYCLES = 1000000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       prog_req,
  input  logic       sck,
  input  logic       mosi,
  output logic       miso,
  output logic       busy,
  output logic [2:0] lock_bits
);
  localparam int AW = $clog2(ARRAY_BYTES);
  localparam logic [14:0] LIMIT = 15'(ARRAY_BYTES);

  logic        frm_valid, load_now;
  logic [23:0] frm_word;
  logic [15:0] head;
  logic [7:0]  load_byte, rd_data;
  cmd_t        cmd;
  logic        prog_en, prog_en_n;
  logic [2:0]  lock_q, lock_n;
  logic        act, start_wr, start_er, wr_in_rng;

  sp_link #(.FRAME_BITS(24)) u_link (
    .clk(clk), .rst_n(rst_n), .prog_req(prog_req), .sck(sck), .mosi(mosi),
    .load_byte(load_byte), .frm_valid(frm_valid), .frm_word(frm_word),
    .head(head), .load_now(load_now), .miso(miso)
  );

  sp_decode u_dec (.word(frm_word), .cmd(cmd));

  sp_store #(.DEPTH(ARRAY_BYTES), .WR_CYC(WRITE_CYCLES), .ER_CYC(ERASE_CYCLES)) u_store (
    .clk(clk), .rst_n(rst_n), .start_wr(start_wr), .start_er(start_er),
    .wr_addr(cmd.addr[AW-1:0]), .wr_data(cmd.data),
    .rd_addr({head[15:10], head[7:0]}), .busy(busy), .rd_data(rd_data)
  );

  // Read data is loaded when byte 2 has fully arrived; served even while busy.
  assign load_byte = (prog_en && head[9:8] == 2'b01) ? rd_data : 8'h00;

  assign wr_in_rng = ({1'b0, cmd.addr} < LIMIT);
  assign act       = frm_valid && prog_en && !busy;
  assign start_wr  = act && (cmd.op == OP_WRITE) && wr_in_rng;
  assign start_er  = act && (cmd.op == OP_ERASE);

  always_comb begin
    prog_en_n = prog_en;
    lock_n    = lock_q;
    if (!prog_req)                              prog_en_n = 1'b0;
    else if (frm_valid && cmd.op == OP_ENABLE)  prog_en_n = 1'b1;
    if (start_er)                               lock_n = '0;
    else if (act && cmd.op == OP_LOCK)          lock_n = lock_q | cmd.lock_set;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prog_en <= 1'b0;
      lock_q  <= '0;
    end else begin
      prog_en <= prog_en_n;
      lock_q  <= lock_n;
    end
  end

  assign lock_bits = lock_q;
endmodule

// File: rtl/sprog_if_chk.sv
module sprog_if_chk #(
  parameter int WR_CYC = 100000,
  parameter int ER_CYC = 1000000
) (
  input logic       clk,
  input logic       rst_n,
  input logic       prog_req,
  input logic       busy,
  input logic       frm_valid,
  input logic       prog_en,
  input logic       start_er,
  input logic [2:0] lock_bits
);
  logic [31:0] run_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    run_len <= '0;
    else if (busy) run_len <= run_len + 1'b1;
    else           run_len <= '0;
  end

  assert_busy_len_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (run_len == 32'(WR_CYC) || run_len == 32'(ER_CYC)));

  assert_busy_after_frame_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(frm_valid));

  assert_enable_drop_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !prog_req |=> !prog_en);

  assert_frame_gate_R2: assert property (@(posedge clk) disable iff (!rst_n)
    frm_valid |-> prog_req);

  assert_lock_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !start_er |=> ((lock_bits & $past(lock_bits)) == $past(lock_bits)));
endmodule

bind sprog_if sprog_if_chk #(.WR_CYC(WRITE_CYCLES), .ER_CYC(ERASE_CYCLES)) u_chk (
  .clk(clk), .rst_n(rst_n), .prog_req(prog_req), .busy(busy),
  .frm_valid(frm_valid), .prog_en(prog_en), .start_er(start_er),
  .lock_bits(lock_bits)
);

// File: tb/tb_sprog_if.sv
module tb_sprog_if;
  localparam int DEPTH = 2048;
  localparam int WRC   = 1000;
  localparam int ERC   = 3000;

  logic clk, rst_n, prog_req, sck, mosi;
  logic miso, busy;
  logic [2:0] lock_bits;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  logic [7:0] ref_mem [DEPTH];
  logic [2:0] ref_lock;

  sprog_if #(.ARRAY_BYTES(DEPTH), .WRITE_CYCLES(WRC), .ERASE_CYCLES(ERC)) dut (
    .clk(clk), .rst_n(rst_n), .prog_req(prog_req), .sck(sck), .mosi(mosi),
    .miso(miso), .busy(busy), .lock_bits(lock_bits)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_read(input logic [13:0] a);
    if (a >= 14'(DEPTH)) return 8'hFF;
    return ref_mem[a[10:0]];
  endfunction

  task automatic send_bits(input logic [23:0] w, input int nbits, output logic [7:0] rx);
    rx = 8'h00;
    for (int i = 23; i > 23 - nbits; i--) begin
      mosi = w[i];
      repeat (6) @(negedge clk);
      if (i < 8) rx[i] = miso;
      sck = 1'b1;
      repeat (6) @(negedge clk);
      sck = 1'b0;
    end
    repeat (6) @(negedge clk);
  endtask

  task automatic frame(input logic [7:0] b1, input logic [7:0] b2, input logic [7:0] b3,
                       output logic [7:0] rx);
    send_bits({b1, b2, b3}, 24, rx);
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic rd(input logic [13:0] a, output logic [7:0] d);
    frame({a[13:8], 2'b01}, a[7:0], 8'h00, d);
  endtask

  task automatic wr(input logic [13:0] a, input logic [7:0] d);
    logic [7:0] rx;
    frame({a[13:8], 2'b10}, a[7:0], d, rx);
  endtask

  task automatic enable();
    logic [7:0] rx;
    frame(8'hAC, 8'h53, 8'h00, rx);
  endtask

  task automatic erase();
    logic [7:0] rx;
    frame(8'hAC, 8'hF4, 8'h5A, rx);
    chk(busy === 1'b1, "R4 busy after erase", busy, 1);
    wait_idle();
    for (int i = 0; i < DEPTH; i++) ref_mem[i] = 8'hFF;
    ref_lock = 3'b000;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    logic [13:0] a;
    int t0, len;
    void'($urandom(32'd1234));
    rst_n = 1'b0; prog_req = 1'b0; sck = 1'b0; mosi = 1'b0;
    ref_lock = 3'b000;
    repeat (5) @(negedge clk);
    chk(busy === 1'b0 && lock_bits === 3'b000 && miso === 1'b0, "R12 reset outputs",
        {busy, lock_bits, miso}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    prog_req = 1'b1;
    repeat (3) @(negedge clk);

    // R3: read before enable gives 00h, erase before enable does nothing
    rd(14'd5, d);
    chk(d === 8'h00, "R3 read before enable", d, 0);
    frame(8'hAC, 8'h04, 8'h00, d);
    chk(busy === 1'b0, "R3 erase before enable ignored", busy, 0);

    enable();
    erase();
    rd(14'd5, d);
    chk(d === 8'hFF, "R4 erased byte", d, 8'hFF);
    rd(14'd2047, d);
    chk(d === 8'hFF, "R4 erased last byte", d, 8'hFF);

    // R8: busy length for a write
    wr(14'd10, 8'h5A);
    t0 = 0;
    while (busy) begin @(negedge clk); t0++; end
    len = t0;
    chk(len > WRC - 20 && len <= WRC, "R8 write busy length", len, WRC);
    ref_mem[10] = 8'h5A;
    rd(14'd10, d);
    chk(d === 8'h5A, "R6 first write", d, 8'h5A);
    wr(14'd10, 8'hF0); wait_idle();
    ref_mem[10] = 8'h50;
    rd(14'd10, d);
    chk(d === 8'h50, "R6 write ANDs", d, 8'h50);

    // R7: data polling
    wr(14'd20, 8'h3C);
    rd(14'd20, d);
    chk(d === 8'h80, "R7 poll bit7 complement", d, 8'h80);
    rd(14'd21, d);
    chk(d === 8'hFF, "R7 other address true", d, 8'hFF);
    wait_idle();
    ref_mem[20] = 8'h3C;
    rd(14'd20, d);
    chk(d === 8'h3C, "R7 after busy true byte", d, 8'h3C);
    wr(14'd22, 8'hC3);
    rd(14'd22, d);
    chk(d === 8'h00, "R7 poll bit7 set", d, 8'h00);
    wait_idle();
    ref_mem[22] = 8'hC3;

    // R9: write while busy ignored
    wr(14'd30, 8'h11);
    wr(14'd31, 8'h22);
    wait_idle();
    ref_mem[30] = 8'h11;
    rd(14'd31, d);
    chk(d === 8'hFF, "R9 write during busy ignored", d, 8'hFF);
    rd(14'd30, d);
    chk(d === 8'h11, "R9 first write kept", d, 8'h11);

    // R10: out of range
    wr(14'd12000, 8'h00);
    chk(busy === 1'b0, "R10 out-of-range write no busy", busy, 0);
    rd(14'd12000, d);
    chk(d === 8'hFF, "R10 out-of-range read", d, 8'hFF);
    rd(14'h3FFF, d);
    chk(d === 8'hFF, "R10 top address read", d, 8'hFF);
    rd(14'h0800 | 14'd10, d);
    chk(d === 8'hFF, "R10 no aliasing", d, 8'hFF);

    // R11: lock bits, bit5=LB1, bit4=LB2, bit3=LB3, 0 programs
    frame(8'hAC, 8'b0001_1111, 8'h00, d);
    chk(lock_bits === 3'b001, "R11 program LB1", lock_bits, 3'b001);
    frame(8'hAC, 8'b0011_0111, 8'h00, d);
    chk(lock_bits === 3'b101, "R11 program LB3", lock_bits, 3'b101);
    frame(8'hAC, 8'b1111_1111, 8'h00, d);
    chk(lock_bits === 3'b101, "R11 locks sticky", lock_bits, 3'b101);

    // R1/R2: incomplete frame, then mode drop
    send_bits({8'h00, 8'h40, 8'h00}, 23, d);
    chk(busy === 1'b0, "R1 no action on 23 bits", busy, 0);
    prog_req = 1'b0;
    repeat (4) @(negedge clk);
    chk(lock_bits === 3'b101, "R2 locks kept over mode drop", lock_bits, 3'b101);
    wr(14'd40, 8'h00);
    chk(busy === 1'b0, "R2 frame ignored while prog_req low", busy, 0);
    prog_req = 1'b1;
    repeat (3) @(negedge clk);
    wr(14'd40, 8'h00);
    chk(busy === 1'b0, "R2 enable lost after mode drop", busy, 0);
    enable();
    rd(14'd40, d);
    chk(d === 8'hFF, "R1 counter realigned, R2 write ignored", d, 8'hFF);

    erase();
    chk(lock_bits === 3'b000, "R4 erase clears locks", lock_bits, 0);

    // Random phase
    for (int k = 0; k < 60; k++) begin
      int r;
      r = $urandom % 10;
      a = (($urandom % 8) == 0) ? 14'($urandom) : 14'($urandom % DEPTH);
      if (r < 5) begin
        rd(a, d);
        chk(d === exp_read(a), "R5 random read", d, exp_read(a));
      end else if (r < 9) begin
        logic [7:0] v;
        v = 8'($urandom);
        wr(a, v);
        if (a >= 14'(DEPTH))
          chk(busy === 1'b0, "R10 random out-of-range write", busy, 0);
        else
          ref_mem[a[10:0]] = ref_mem[a[10:0]] & v;
        wait_idle();
      end else begin
        logic [2:0] m;
        m = 3'($urandom);
        frame(8'hAC, {2'b00, m, 3'b111}, 8'h00, d);
        ref_lock = ref_lock | ~{m[0], m[1], m[2]};
        chk(lock_bits === ref_lock, "R11 random lock", lock_bits, ref_lock);
      end
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule